// File: doc/BRIEF.md
# Multiplexed LCD segment drive sequencer

This block generates the digital drive pattern for a segment LCD with up to four common electrodes (backplanes) and sixty segment electrodes. A display memory holds one 4-bit word per segment column. Bit k of a column belongs to the element where that segment crosses backplane k. A stored 1 lights the element and a stored 0 leaves it dark. A mode input selects static drive or 1:2, 1:3 or 1:4 multiplexing. A frame-clock enable steps the block from one time slot to the next.

In every time slot the block presents a 2-bit level code on each backplane output and on each segment output. Code 00 names ground and 11 names full scale. Codes 01 and 10 name the lower and upper intermediate bias levels. An external analog stage turns the codes into voltages. The drive polarity flips after every complete frame so that the drive carries no net DC. Writes land in the memory at once. A column's new value reaches the segment outputs only at the next time-slot boundary, so the outputs never change partway through a slot.

Top module: `lcd_mux_seq`

## Requirements
- R1: Reset clears every memory bit and sets the slot to 0 and the polarity to 0, with 1:4 as the held mode. Right after reset, BP0 shows 11, BP1 to BP3 show 01 and every segment shows 10.
- R2: When wr_en is high at a clock edge, wr_data is stored in column wr_addr, with bit k going to row k. A write to an address of NUM_SEG or above changes nothing.
- R3: The segment outputs change only in the cycle after a slot boundary. A slot boundary is a frame_en pulse or a mode change. Data written in any cycle shows up no earlier than the next boundary after the write, and never within the current slot.
- R4: Each frame_en pulse advances the slot by one. The slot wraps to 0 after N slots, where N is 1, 2, 3 or 4 for mode 00 (static), 01 (1:2), 10 (1:3) and 11 (1:4).
- R5: A clock edge at which mode differs from the held mode adopts the new mode and sets the slot and the polarity to 0. A frame_en pulse at that same edge is ignored.
- R6: The polarity toggles at every wrap from the last slot to slot 0, and at no other frame_en pulse.
- R7: In the multiplexed modes, the active backplane shows 11 at polarity 0 and 00 at polarity 1. Every other backplane shows 01 at polarity 0 and 10 at polarity 1.
- R8: Backplane k is active when its row equals the slot. In 1:4, backplane k uses row k, so exactly one backplane is active. In 1:3, BP3 uses row 1 and always equals BP1. In 1:2, BP2 equals BP0 and BP3 equals BP1.
- R9: In static mode, all four backplanes show 11 at polarity 0 and 00 at polarity 1.
- R10: In the multiplexed modes, a segment whose latched bit for the current slot's row is 1 shows 00 at polarity 0 and 11 at polarity 1. A segment whose bit is 0 shows 10 at polarity 0 and 01 at polarity 1.
- R11: In static mode, a segment whose row-0 bit is 1 shows the opposite of the backplane (00 at polarity 0, 11 at polarity 1). A segment whose bit is 0 shows the same level as the backplane.
- R12: Column n drives seg_code[2n+1:2n], and backplane k drives bp_code[2k+1:2k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the display memory |
| wr_addr | input | 6 | Column address of the write (ADDR_W) |
| wr_data | input | 4 | Column word, bit k belongs to row k |
| mode | input | 2 | 00 static, 01 1:2, 10 1:3, 11 1:4 |
| frame_en | input | 1 | Time-slot advance pulse |
| bp_code | output | 8 | Four backplane level codes, 2 bits each |
| seg_code | output | 120 | Segment level codes, 2 bits per column (2*NUM_SEG) |

## Verification
The bench builds the block with the default of sixty columns. At that size the 6-bit address reaches the last real column, 59, and also the four unused codes, 60 to 63, so writes outside the memory are exercised. Directed steps walk each mode through a full frame and back to slot 0 at both polarities. They include a mode change that lands on the same edge as frame_en. A long random phase then mixes writes, frame pulses and rare mode changes, so that every row is latched in every mode.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_1_2    = 2'b01,
    MODE_1_3    = 2'b10,
    MODE_1_4    = 2'b11
  } mux_mode_e;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_LO   = 2'b01;
  localparam lvl_t LVL_HI   = 2'b10;
  localparam lvl_t LVL_FULL = 2'b11;

  localparam int NUM_BP = 4;
  localparam int ROW_W  = 2;

  // index of the final slot of a frame (slot count minus one)
  function automatic logic [ROW_W-1:0] last_slot(mux_mode_e m);
    return ROW_W'(m);
  endfunction

  // memory row that a given backplane output follows in a given mode
  function automatic logic [ROW_W-1:0] bp_row_of(mux_mode_e m, logic [ROW_W-1:0] k);
    logic [ROW_W-1:0] r;
    case (m)
      MODE_STATIC: r = '0;
      MODE_1_2:    r = {1'b0, k[0]};
      MODE_1_3:    r = (k == 2'd3) ? 2'd1 : k;
      default:     r = k;
    endcase
    return r;
  endfunction

  function automatic lvl_t bp_level(mux_mode_e m, logic active, logic pol);
    lvl_t l;
    if (m == MODE_STATIC || active) l = pol ? LVL_GND : LVL_FULL;
    else                            l = pol ? LVL_HI  : LVL_LO;
    return l;
  endfunction

  function automatic lvl_t seg_level(mux_mode_e m, logic on, logic pol);
    lvl_t l;
    if (on)                    l = pol ? LVL_FULL : LVL_GND;
    else if (m == MODE_STATIC) l = pol ? LVL_GND  : LVL_FULL;
    else                       l = pol ? LVL_LO   : LVL_HI;
    return l;
  endfunction

endpackage

// File: rtl/lcd_slot_ctrl.sv
module lcd_slot_ctrl
  import lcd_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  mux_mode_e            mode_in,
  input  logic                 frame_en,
  output mux_mode_e            mode_q,
  output logic [ROW_W-1:0]     slot_q,
  output logic [ROW_W-1:0]     slot_next,
  output logic                 pol_q,
  output logic                 boundary,
  output logic                 frame_wrap,
  output logic                 mode_change
);

  logic at_last;

  assign mode_change = (mode_in != mode_q);
  assign at_last     = (slot_q == last_slot(mode_q));
  assign frame_wrap  = !mode_change && frame_en && at_last;
  assign boundary    = mode_change || frame_en;

  always_comb begin
    if (mode_change)   slot_next = '0;
    else if (frame_en) slot_next = at_last ? '0 : slot_q + 1'b1;
    else               slot_next = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_1_4;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      mode_q <= mode_in;
      slot_q <= slot_next;
      if (mode_change)     pol_q <= 1'b0;
      else if (frame_wrap) pol_q <= ~pol_q;
    end
  end

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int ADDR_W  = $clog2(NUM_SEG)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_BP-1:0]   wr_data,
  input  logic [ROW_W-1:0]    rd_row,
  output logic [NUM_SEG-1:0]  row_bits
);

  for (genvar c = 0; c < NUM_SEG; c++) begin : g_col
    logic [NUM_BP-1:0] word_q;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end

    assign row_bits[c] = word_q[rd_row];
  end

endmodule

// File: rtl/lcd_bp_drive.sv
module lcd_bp_drive
  import lcd_mux_pkg::*;
(
  input  mux_mode_e               mode_q,
  input  logic [ROW_W-1:0]        slot_q,
  input  logic                    pol_q,
  output logic [2*NUM_BP-1:0]     bp_code
);

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    logic active;
    assign active = (bp_row_of(mode_q, ROW_W'(k)) == slot_q);
    assign bp_code[2*k +: 2] = bp_level(mode_q, active, pol_q);
  end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG = 60
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NUM_SEG-1:0]    row_in,
  input  mux_mode_e             mode_q,
  input  logic                  pol_q,
  output logic [2*NUM_SEG-1:0]  seg_code
);

  logic [NUM_SEG-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (load) row_q <= row_in;
  end

  for (genvar c = 0; c < NUM_SEG; c++) begin : g_seg
    assign seg_code[2*c +: 2] = seg_level(mode_q, row_q[c], pol_q);
  end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG = 60,
  localparam int ADDR_W = $clog2(NUM_SEG)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [3:0]            wr_data,
  input  logic [1:0]            mode,
  input  logic                  frame_en,
  output logic [7:0]            bp_code,
  output logic [2*NUM_SEG-1:0]  seg_code
);

  mux_mode_e          mode_q;
  logic [ROW_W-1:0]   slot_q;
  logic [ROW_W-1:0]   slot_next;
  logic               pol_q;
  logic               boundary;
  logic               frame_wrap;
  logic               mode_change;
  logic [NUM_SEG-1:0] next_row_bits;

  lcd_slot_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_in     (mux_mode_e'(mode)),
    .frame_en    (frame_en),
    .mode_q      (mode_q),
    .slot_q      (slot_q),
    .slot_next   (slot_next),
    .pol_q       (pol_q),
    .boundary    (boundary),
    .frame_wrap  (frame_wrap),
    .mode_change (mode_change)
  );

  lcd_disp_ram #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_row   (slot_next),
    .row_bits (next_row_bits)
  );

  lcd_bp_drive u_bp (
    .mode_q  (mode_q),
    .slot_q  (slot_q),
    .pol_q   (pol_q),
    .bp_code (bp_code)
  );

  lcd_seg_drive #(.NUM_SEG(NUM_SEG)) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .row_in   (next_row_bits),
    .mode_q   (mode_q),
    .pol_q    (pol_q),
    .seg_code (seg_code)
  );

endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NUM_SEG = 60
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode_q,
  input logic [1:0]           slot_q,
  input logic                 pol_q,
  input logic                 boundary,
  input logic                 frame_wrap,
  input logic                 mode_change,
  input logic [7:0]           bp_code,
  input logic [2*NUM_SEG-1:0] seg_code
);

  logic [1:0] act_code;
  logic [3:0] act_vec;

  assign act_code = pol_q ? 2'b00 : 2'b11;
  for (genvar k = 0; k < 4; k++) begin : g_act
    assign act_vec[k] = (bp_code[2*k +: 2] == act_code);
  end

  assert_seg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(seg_code));

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= mode_q);

  assert_mode_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> (slot_q == 2'd0) && !pol_q);

  assert_pol_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> pol_q != $past(pol_q));

  assert_pol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap && !mode_change |=> $stable(pol_q));

  assert_one_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b11 |-> $countones(act_vec) == 1);

  assert_copy_1_3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b10 |-> bp_code[7:6] == bp_code[3:2]);

  assert_pair_1_2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b01 |-> (bp_code[5:4] == bp_code[1:0]) && (bp_code[7:6] == bp_code[3:2]));

  assert_static_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b00 |-> act_vec == 4'b1111);

endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .slot_q      (slot_q),
  .pol_q       (pol_q),
  .boundary    (boundary),
  .frame_wrap  (frame_wrap),
  .mode_change (mode_change),
  .bp_code     (bp_code),
  .seg_code    (seg_code)
);

// File: tb/lcd_mux_seq_tb_top.sv
module lcd_mux_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG       = 60;
  localparam int AW         = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [3:0]        wr_data = '0;
  logic [1:0]        mode = 2'b11;
  logic              frame_en = 1'b0;
  logic [7:0]        bp_code;
  logic [2*NSEG-1:0] seg_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  // behavioural reference state
  int m_ram   [NSEG];
  int m_latch [NSEG];
  int m_slot, m_pol, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_seq #(.NUM_SEG(NSEG)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode     (mode),
    .frame_en (frame_en),
    .bp_code  (bp_code),
    .seg_code (seg_code)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bpf(int k);
    return int'(bp_code[2*k +: 2]);
  endfunction

  function automatic int segf(int c);
    return int'(seg_code[2*c +: 2]);
  endfunction

  function automatic int exp_bp(int k);
    int r;
    if (m_mode == 0) return m_pol ? 0 : 3;
    if (m_mode == 1)      r = k % 2;
    else if (m_mode == 2) r = (k == 3) ? 1 : k;
    else                  r = k;
    if (r == m_slot) return m_pol ? 0 : 3;
    return m_pol ? 2 : 1;
  endfunction

  function automatic int exp_seg(int c);
    if (m_latch[c] != 0) return m_pol ? 3 : 0;
    if (m_mode == 0)     return m_pol ? 0 : 3;
    return m_pol ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ram[i])   m_ram[i] = 0;
      foreach (m_latch[i]) m_latch[i] = 0;
      m_slot = 0; m_pol = 0; m_mode = 3;
    end else begin
      bit edge_b;
      edge_b = 0;
      if (int'(mode) != m_mode) begin
        m_mode = int'(mode); m_slot = 0; m_pol = 0; edge_b = 1;
      end else if (frame_en) begin
        if (m_slot == m_mode) begin m_slot = 0; m_pol = 1 - m_pol; end
        else m_slot = m_slot + 1;
        edge_b = 1;
      end
      if (edge_b)
        foreach (m_latch[i]) m_latch[i] = (m_ram[i] >> m_slot) & 1;
      if (wr_en && int'(wr_addr) < NSEG) m_ram[int'(wr_addr)] = int'(wr_data);
    end
  end

  task automatic cmp_segs(string req);
    for (int c = 0; c < NSEG; c++) chk(segf(c) == exp_seg(c), req, segf(c), exp_seg(c));
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      for (int k = 0; k < 4; k++)
        chk(bpf(k) == exp_bp(k), (m_mode == 0) ? "R9" : "R7", bpf(k), exp_bp(k));
      cmp_segs((m_mode == 0) ? "R11" : "R10");
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 4'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      frame_en = 1'b1;
      @(negedge clk);
      frame_en = 1'b0;
    end
  endtask

  task automatic set_mode(int m);
    mode = 2'(m);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk(bpf(0) == 3, "R1", bpf(0), 3);
    chk(bpf(1) == 1, "R1", bpf(1), 1);
    chk(bpf(3) == 1, "R1", bpf(3), 1);
    chk(segf(0) == 2, "R1", segf(0), 2);
    chk(segf(59) == 2, "R1", segf(59), 2);

    // R3 deferred write, R12 field position, R6 polarity after wrap
    wr(7, 4'b0001);
    chk(segf(7) == 2, "R3", segf(7), 2);
    pulse(4);
    chk(segf(7) == 3, "R12", segf(7), 3);
    chk(segf(6) == 1, "R12", segf(6), 1);
    chk(bpf(0) == 0, "R6", bpf(0), 0);

    // R2 out-of-range writes leave all columns untouched
    wr(60, 15); wr(62, 15); wr(63, 15);
    for (int s = 0; s < 4; s++) begin
      pulse(1);
      cmp_segs("R2");
      chk(segf(59) == exp_seg(59), "R2", segf(59), exp_seg(59));
    end

    // 1:3 mode
    set_mode(2);
    chk(bpf(0) == 3, "R5", bpf(0), 3);
    pulse(3);
    chk(bpf(0) == 0, "R4", bpf(0), 0);
    chk(bpf(3) == bpf(1), "R8", bpf(3), bpf(1));
    pulse(1);
    chk(bpf(1) == 0, "R8", bpf(1), 0);
    chk(bpf(3) == 0, "R8", bpf(3), 0);

    // 1:2 mode
    set_mode(1);
    pulse(1);
    chk(bpf(1) == 3, "R8", bpf(1), 3);
    chk(bpf(3) == 3, "R8", bpf(3), 3);
    chk(bpf(0) == 1, "R8", bpf(0), 1);
    chk(bpf(2) == 1, "R8", bpf(2), 1);
    pulse(1);
    chk(bpf(0) == 0, "R4", bpf(0), 0);

    // static mode
    set_mode(0);
    for (int k = 0; k < 4; k++) chk(bpf(k) == 3, "R9", bpf(k), 3);
    chk(segf(7) == 0, "R11", segf(7), 0);
    chk(segf(6) == 3, "R11", segf(6), 3);
    pulse(1);
    for (int k = 0; k < 4; k++) chk(bpf(k) == 0, "R9", bpf(k), 0);
    chk(segf(7) == 3, "R11", segf(7), 3);

    // R5 mode change wins over a same-edge frame pulse
    mode = 2'b11; frame_en = 1'b1;
    @(negedge clk);
    frame_en = 1'b0;
    chk(bpf(0) == 3, "R5", bpf(0), 3);
    chk(bpf(1) == 1, "R5", bpf(1), 1);

    // random phase, reference compared every cycle
    for (int i = 0; i < 4000; i++) begin
      frame_en = ($urandom % 4) == 0;
      wr_en    = ($urandom % 2) == 0;
      wr_addr  = AW'($urandom % 64);
      wr_data  = 4'($urandom);
      if (($urandom % 150) == 0) mode = 2'($urandom);
      @(negedge clk);
    end
    frame_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule